// File: doc/BRIEF.md
# FIFO Depth and Trigger Threshold Controller

This block sits next to the receive and transmit FIFOs of a serial port. From the FIFO control fields, an enhanced-function enable bit and four extended level registers, it decides how deep the FIFOs are. The depth is a single holding entry when FIFOs are off. It is 32 entries in legacy mode, when all four level registers are zero. It is 128 entries in extended mode, when any of them is nonzero. The block also works out the receive and transmit interrupt thresholds for the active mode.

The block compares the live RX and TX fill counts against those thresholds and raises two trigger flags. Whenever the effective depth changes, it emits a one-cycle flush pulse. The FIFO logic uses that pulse to discard its contents and zero its fill counters.

Thresholds, depth and the flush pulse are registered. They reflect the configuration inputs from the first rising clock edge after those inputs change. The trigger flags follow the count inputs combinationally.

Top module: `fifo_trig_ctrl`

## Requirements
- R1: While `rst` is high, and at the first clock edge after it falls with `fifo_en` low, `depth` is 1 and `flush` is 0. The stored legacy TX level is reset to 16.
- R2: With `fifo_en` high, `depth` is 32 when `lvl_tx`, `lvl_rx`, `flow_hi` and `flow_lo` are all zero. It is 128 when any one of them is nonzero.
- R3: In 32-entry mode, `rx_code` values 0, 1, 2 and 3 give RX thresholds of 8, 16, 24 and 28.
- R4: In 32-entry mode, the TX threshold is a stored level. `tx_code` values 0, 1, 2 and 3 map to 16, 8, 24 and 30. The stored level is loaded only on clock edges where `enh_en` is 1; otherwise the previous level stays in force, including across mode changes.
- R5: In 128-entry mode, the RX threshold is `lvl_rx` and the TX threshold is `lvl_tx`. A value of 0 acts as 1, and values above 128 act as 128.
- R6: `rx_trig` is high exactly when `rx_count` is greater than or equal to the RX threshold. `tx_trig` is high exactly when `tx_count` is less than or equal to the TX threshold.
- R7: When the mode (off, 32-entry, 128-entry) seen at a clock edge differs from the one seen at the previous edge, `flush` is high for exactly the following cycle. The new depth and thresholds appear in that same cycle.
- R8: Configuration changes that leave the mode unchanged raise no flush. Examples are editing a nonzero level register to another nonzero value, or changing level registers while `fifo_en` is low.
- R9: With `fifo_en` low, `depth` is 1, the RX threshold is 1 and the TX threshold is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fifo_en | input | 1 | FIFO enable control bit |
| rx_code | input | 2 | Legacy RX trigger select |
| tx_code | input | 2 | Legacy TX trigger select |
| enh_en | input | 1 | Enhanced-function enable; gates loading of the legacy TX level |
| lvl_tx | input | 8 | Extended TX trigger level register |
| lvl_rx | input | 8 | Extended RX trigger level register |
| flow_hi | input | 8 | Flow-control high level register (mode selection only) |
| flow_lo | input | 8 | Flow-control low level register (mode selection only) |
| rx_count | input | 8 | Current RX FIFO fill count |
| tx_count | input | 8 | Current TX FIFO fill count |
| rx_trig | output | 1 | RX fill has reached its threshold |
| tx_trig | output | 1 | TX fill has dropped to its threshold |
| depth | output | 8 | Effective FIFO depth: 1, 32 or 128 |
| flush | output | 1 | One-cycle pulse that empties both FIFOs |

## Verification
The bench drives level-register edits that keep the mode unchanged. A design that watched raw register values instead of their combined zero test would flush on those edits and lose data. It writes TX codes with the enhanced bit low and checks that the old level holds, including after a trip through 128-entry mode. A design missing the gate, or forgetting the stored level, would move the TX threshold early or revert to 16. It also probes each threshold one count below and at the trigger point, and drives the extended value 0 and values above 128. These catch off-by-one comparisons, a zero threshold that fires on an empty FIFO, and unclamped levels beyond the FIFO size.

// File: rtl/fifo_trig_pkg.sv
package fifo_trig_pkg;

    localparam int CNT_W     = 8;
    localparam int LEG_DEPTH = 32;
    localparam int EXT_DEPTH = 128;

    typedef logic [CNT_W-1:0] cnt_t;

    typedef enum logic [1:0] {
        MODE_OFF = 2'd0,
        MODE_LEG = 2'd1,
        MODE_EXT = 2'd2
    } fifo_mode_e;

    typedef struct packed {
        cnt_t rx;
        cnt_t tx;
    } thr_t;

    function automatic cnt_t rx_leg_lvl(input logic [1:0] code);
        case (code)
            2'd0:    return cnt_t'(8);
            2'd1:    return cnt_t'(16);
            2'd2:    return cnt_t'(24);
            default: return cnt_t'(28);
        endcase
    endfunction

    function automatic cnt_t tx_leg_lvl(input logic [1:0] code);
        case (code)
            2'd0:    return cnt_t'(16);
            2'd1:    return cnt_t'(8);
            2'd2:    return cnt_t'(24);
            default: return cnt_t'(30);
        endcase
    endfunction

    function automatic cnt_t ext_lvl(input cnt_t v);
        if (v == '0)
            return cnt_t'(1);
        else if (int'(v) > EXT_DEPTH)
            return cnt_t'(EXT_DEPTH);
        else
            return v;
    endfunction

    function automatic cnt_t depth_of(input fifo_mode_e m);
        case (m)
            MODE_LEG: return cnt_t'(LEG_DEPTH);
            MODE_EXT: return cnt_t'(EXT_DEPTH);
            default:  return cnt_t'(1);
        endcase
    endfunction

endpackage

// File: rtl/ftc_mode_detect.sv
module ftc_mode_detect
    import fifo_trig_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       fifo_en,
    input  logic       lvl_any,
    output fifo_mode_e mode_now,
    output fifo_mode_e mode_q,
    output logic       flush_q
);

    always_comb begin
        if (!fifo_en)
            mode_now = MODE_OFF;
        else if (lvl_any)
            mode_now = MODE_EXT;
        else
            mode_now = MODE_LEG;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q  <= MODE_OFF;
            flush_q <= 1'b0;
        end else begin
            mode_q  <= mode_now;
            flush_q <= (mode_now != mode_q);
        end
    end

    // R9: a disabled FIFO never reports an extended mode
    a_r9_off_mode: assert property (@(posedge clk) disable iff (rst)
        !fifo_en |=> (mode_q == MODE_OFF));

endmodule

// File: rtl/ftc_level_sel.sv
module ftc_level_sel
    import fifo_trig_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  fifo_mode_e mode_now,
    input  fifo_mode_e mode_q,
    input  logic       enh_en,
    input  logic [1:0] rx_code,
    input  logic [1:0] tx_code,
    input  cnt_t       lvl_rx,
    input  cnt_t       lvl_tx,
    output thr_t       thr_q
);

    cnt_t tx_leg_q;
    cnt_t tx_leg_next;
    thr_t thr_next;

    assign tx_leg_next = enh_en ? tx_leg_lvl(tx_code) : tx_leg_q;

    always_comb begin
        case (mode_now)
            MODE_LEG: begin
                thr_next.rx = rx_leg_lvl(rx_code);
                thr_next.tx = tx_leg_next;
            end
            MODE_EXT: begin
                thr_next.rx = ext_lvl(lvl_rx);
                thr_next.tx = ext_lvl(lvl_tx);
            end
            default: begin
                thr_next.rx = cnt_t'(1);
                thr_next.tx = '0;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            tx_leg_q <= cnt_t'(16);
            thr_q    <= '{rx: cnt_t'(1), tx: '0};
        end else begin
            tx_leg_q <= tx_leg_next;
            thr_q    <= thr_next;
        end
    end

    // R4: without the enable bit the legacy TX threshold does not move
    a_r4_tx_hold: assert property (@(posedge clk) disable iff (rst)
        (!enh_en && mode_now == MODE_LEG && mode_q == MODE_LEG) |=> $stable(thr_q.tx));

endmodule

// File: rtl/ftc_trig_cmp.sv
module ftc_trig_cmp
    import fifo_trig_pkg::*;
(
    input  cnt_t rx_count,
    input  cnt_t tx_count,
    input  thr_t thr,
    output logic rx_trig,
    output logic tx_trig
);

    assign rx_trig = (rx_count >= thr.rx);
    assign tx_trig = (tx_count <= thr.tx);

endmodule

// File: rtl/fifo_trig_ctrl.sv
module fifo_trig_ctrl
    import fifo_trig_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       fifo_en,
    input  logic [1:0] rx_code,
    input  logic [1:0] tx_code,
    input  logic       enh_en,
    input  logic [7:0] lvl_tx,
    input  logic [7:0] lvl_rx,
    input  logic [7:0] flow_hi,
    input  logic [7:0] flow_lo,
    input  logic [7:0] rx_count,
    input  logic [7:0] tx_count,
    output logic       rx_trig,
    output logic       tx_trig,
    output logic [7:0] depth,
    output logic       flush
);

    fifo_mode_e mode_now;
    fifo_mode_e mode_q;
    thr_t       thr_q;
    logic       lvl_any;

    assign lvl_any = |{lvl_tx, lvl_rx, flow_hi, flow_lo};

    ftc_mode_detect u_mode (
        .clk      (clk),
        .rst      (rst),
        .fifo_en  (fifo_en),
        .lvl_any  (lvl_any),
        .mode_now (mode_now),
        .mode_q   (mode_q),
        .flush_q  (flush)
    );

    ftc_level_sel u_lvl (
        .clk      (clk),
        .rst      (rst),
        .mode_now (mode_now),
        .mode_q   (mode_q),
        .enh_en   (enh_en),
        .rx_code  (rx_code),
        .tx_code  (tx_code),
        .lvl_rx   (lvl_rx),
        .lvl_tx   (lvl_tx),
        .thr_q    (thr_q)
    );

    ftc_trig_cmp u_cmp (
        .rx_count (rx_count),
        .tx_count (tx_count),
        .thr      (thr_q),
        .rx_trig  (rx_trig),
        .tx_trig  (tx_trig)
    );

    assign depth = depth_of(mode_q);

    // R7: every change of depth comes with a flush, and every flush with a depth change
    a_r7_flush_on_change: assert property (@(posedge clk) disable iff (rst)
        (depth != $past(depth)) |-> flush);
    a_r7_change_on_flush: assert property (@(posedge clk) disable iff (rst)
        flush |-> (depth != $past(depth)));
    // R3: legacy RX threshold is one of the four coded levels
    a_r3_legacy_rx_set: assert property (@(posedge clk) disable iff (rst)
        (depth == 8'd32) |-> (thr_q.rx inside {8'd8, 8'd16, 8'd24, 8'd28}));
    // R5: extended thresholds stay within 1..128
    a_r5_ext_range: assert property (@(posedge clk) disable iff (rst)
        (depth == 8'd128) |-> (thr_q.rx >= 8'd1 && thr_q.rx <= 8'd128 &&
                               thr_q.tx >= 8'd1 && thr_q.tx <= 8'd128));
    // R6: an empty RX FIFO never triggers
    a_r6_empty_rx_quiet: assert property (@(posedge clk) disable iff (rst)
        (rx_count == 8'd0) |-> !rx_trig);

endmodule

// File: tb/fifo_trig_ctrl_tb.sv
`timescale 1ns/1ps
module fifo_trig_ctrl_tb;

    logic       clk = 1'b0;
    logic       rst;
    logic       fifo_en;
    logic [1:0] rx_code, tx_code;
    logic       enh_en;
    logic [7:0] lvl_tx, lvl_rx, flow_hi, flow_lo;
    logic [7:0] rx_count, tx_count;
    logic       rx_trig, tx_trig, flush;
    logic [7:0] depth;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    fifo_trig_ctrl u_dut (
        .clk(clk), .rst(rst), .fifo_en(fifo_en), .rx_code(rx_code), .tx_code(tx_code),
        .enh_en(enh_en), .lvl_tx(lvl_tx), .lvl_rx(lvl_rx), .flow_hi(flow_hi),
        .flow_lo(flow_lo), .rx_count(rx_count), .tx_count(tx_count),
        .rx_trig(rx_trig), .tx_trig(tx_trig), .depth(depth), .flush(flush)
    );

    task automatic check(input int act, input int exp, input string tag);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic check_rx_thr(input int thr, input string tag);
        @(negedge clk);
        rx_count = 8'(thr - 1); #0.5;
        check(int'(rx_trig), 0, {tag, " rx below"});
        rx_count = 8'(thr); #0.5;
        check(int'(rx_trig), 1, {tag, " rx at"});
    endtask

    task automatic check_tx_thr(input int thr, input string tag);
        @(negedge clk);
        tx_count = 8'(thr); #0.5;
        check(int'(tx_trig), 1, {tag, " tx at"});
        tx_count = 8'(thr + 1); #0.5;
        check(int'(tx_trig), 0, {tag, " tx above"});
    endtask

    // R7: pulse in the cycle after the change edge, gone one cycle later
    task automatic expect_flush(input string tag);
        step();
        check(int'(flush), 1, {tag, " R7 flush high"});
        step();
        check(int'(flush), 0, {tag, " R7 flush one cycle"});
    endtask

    task automatic expect_no_flush(input string tag);
        step();
        check(int'(flush), 0, {tag, " R8 no flush"});
        step();
        check(int'(flush), 0, {tag, " R8 no flush later"});
    endtask

    task automatic t_reset();
        check(int'(depth), 1, "R1 depth in reset");
        check(int'(flush), 0, "R1 flush in reset");
        @(negedge clk) rst = 1'b0;
        step();
        check(int'(depth), 1, "R1 depth after reset");
        check(int'(flush), 0, "R1 flush after reset");
        check_rx_thr(1, "R9 off");
        check_tx_thr(0, "R9 off");
    endtask

    task automatic t_legacy();
        @(negedge clk) fifo_en = 1'b1;
        expect_flush("enable");
        check(int'(depth), 32, "R2 legacy depth");
        check_tx_thr(16, "R1 R4 reset tx level");
        for (int c = 0; c < 4; c++) begin
            @(negedge clk) rx_code = 2'(c);
            step();
            check_rx_thr(c == 0 ? 8 : c == 1 ? 16 : c == 2 ? 24 : 28, "R3 code");
        end
        @(negedge clk) tx_code = 2'd1;
        step();
        check_tx_thr(16, "R4 gated hold");
        for (int c = 0; c < 4; c++) begin
            @(negedge clk) begin enh_en = 1'b1; tx_code = 2'(c); end
            step();
            check_tx_thr(c == 0 ? 16 : c == 1 ? 8 : c == 2 ? 24 : 30, "R4 code");
        end
        @(negedge clk) begin enh_en = 1'b0; tx_code = 2'd0; end
        step();
        check_tx_thr(30, "R4 hold after enable drop");
    endtask

    task automatic t_extended();
        @(negedge clk) lvl_rx = 8'd5;
        expect_flush("to ext");
        check(int'(depth), 128, "R2 ext depth");
        check_rx_thr(5, "R5 rx level");
        check_tx_thr(1, "R5 tx zero as one");
        @(negedge clk) lvl_tx = 8'd100;
        expect_no_flush("ext tx edit");
        check_tx_thr(100, "R5 tx level");
        @(negedge clk) begin flow_hi = 8'd7; lvl_rx = 8'd0; end
        expect_no_flush("ext swap nonzero");
        check(int'(depth), 128, "R2 flow reg keeps ext");
        check_rx_thr(1, "R5 rx zero as one");
        @(negedge clk) lvl_rx = 8'd200;
        step();
        check_rx_thr(128, "R5 rx clamp");
        @(negedge clk) lvl_rx = 8'd128;
        step();
        check_rx_thr(128, "R5 rx max");
        @(negedge clk) begin flow_hi = 8'd0; flow_lo = 8'd3; lvl_rx = 8'd0; lvl_tx = 8'd0; end
        expect_no_flush("flow low only");
        check(int'(depth), 128, "R2 flow low keeps ext");
    endtask

    task automatic t_back_and_off();
        @(negedge clk) begin flow_lo = 8'd0; rx_code = 2'd2; end
        expect_flush("to legacy");
        check(int'(depth), 32, "R2 back to legacy");
        check_tx_thr(30, "R4 level kept across modes");
        check_rx_thr(24, "R3 after return");
        @(negedge clk) fifo_en = 1'b0;
        expect_flush("disable");
        check(int'(depth), 1, "R9 depth off");
        check_rx_thr(1, "R9 rx off");
        check_tx_thr(0, "R9 tx off");
        @(negedge clk) lvl_tx = 8'd9;
        expect_no_flush("edit while off");
        check(int'(depth), 1, "R8 still off");
        @(negedge clk) fifo_en = 1'b1;
        expect_flush("enable ext");
        check(int'(depth), 128, "R2 enable into ext");
        check_tx_thr(9, "R5 tx after enable");
    endtask

    initial begin
        rst = 1'b1; fifo_en = 1'b0; rx_code = '0; tx_code = '0; enh_en = 1'b0;
        lvl_tx = '0; lvl_rx = '0; flow_hi = '0; flow_lo = '0;
        rx_count = '0; tx_count = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        t_reset();
        t_legacy();
        t_extended();
        t_back_and_off();
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

endmodule